// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame identifier is accepted. Filter elements sit in a small local word RAM that software loads through a write port. Standard (11-bit) identifiers are checked against one list of one-word elements. Extended (29-bit) identifiers are checked against a second, independent list of two-word elements. Each list is located by a start address and an element count, both given as inputs.

When a frame identifier is presented with a start strobe, the block walks the list selected by the extended-frame flag, one element per clock. It stops at the first element that hits. It then pulses `done` together with an accept/reject verdict, a priority flag and the index of the element that ended the scan. Elements of a type other than classic ID-and-mask are passed over. Elements whose action code is zero are also passed over.

Top module: `can_id_accept_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy`, `done`, `accept` and `prio` are 0 and `hit_idx` is 0.
- R2: `start` is taken only while `busy` is 0. A `start` pulse during a scan does not change that scan's result and produces no extra `done` pulse.
- R3: The standard element i is read from address `std_base + i`. Its fields are: bits 31:30 the type, where 2 means classic; bits 29:27 the action; bits 26:16 the filter ID; bits 10:0 the mask. It hits when `(rx_id[10:0] & mask) == (ID & mask)`.
- R4: The extended element i is read from addresses `ext_base + 2*i` (word 0) and `ext_base + 2*i + 1` (word 1). Word 0 holds the action in bits 31:29 and the ID in bits 28:0. Word 1 holds the type in bits 31:30, where 2 means classic, and the mask in bits 28:0. It hits when `(rx_id & mask) == (ID & mask)`.
- R5: The action code sets the verdict. Action 4 accepts with `prio`=1. Action 3 rejects and stops the scan. Actions 1, 2, 5, 6 and 7 accept with `prio`=0. Action 0 marks the element as disabled, and it is skipped.
- R6: An element whose type field is not 2 never hits, whatever its ID and mask.
- R7: The scan stops at the first element that hits, and `hit_idx` reports that element's index.
- R8: A frame with no hit among the first `count` elements of its list is rejected with `prio`=0 and `hit_idx`=0. This includes a count of 0.
- R9: The start edge is edge k. A hit at element i raises `done` after edge k+1+i. No hit with count N raises it after edge k+1+N. `done` lasts one cycle, and `busy` is 1 from edge k until `done` rises.
- R10: A standard count above MAX_STD (128) is treated as MAX_STD. An extended count above MAX_EXT (64) is treated as MAX_EXT.
- R11: The identifier, the frame flag, the start addresses and the counts are captured at the start edge. Later changes to them do not affect the scan.
- R12: `accept`, `prio` and `hit_idx` change only together with a `done` pulse, and hold their values until the next one.
- R13: For a standard frame, `rx_id[28:11]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Filter RAM write enable |
| wr_addr | input | ADDR_W (8) | Filter RAM write word address |
| wr_data | input | 32 | Filter RAM write data |
| start | input | 1 | Begin filtering `rx_id` (taken when idle) |
| rx_id | input | 29 | Received identifier (standard ID in bits 10:0) |
| rx_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| std_base | input | ADDR_W (8) | Standard list start word address |
| std_count | input | 8 | Standard list element count |
| ext_base | input | ADDR_W (8) | Extended list start word address |
| ext_count | input | 7 | Extended list element count |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted |
| prio | output | 1 | Accepted with priority |
| hit_idx | output | 7 | Index of the element that ended the scan |

## Verification
The properties assume that filter RAM contents do not change while `busy` is high. A scan reads the elements live, so a write during a scan could change its verdict in ways the checks do not model. The stimulus therefore writes to the RAM only between scans. The properties also assume that `start` is a single-cycle pulse sampled in an idle cycle. The stimulus keeps to this, except in the one case where it deliberately pulses `start` during a scan to check that the pulse is ignored. Counts above the list maxima are sent on purpose, because the clamp is part of the defined behaviour.

// File: rtl/cif_pkg.sv
package cif_pkg;

   localparam int WORD_W = 32;
   localparam int XID_W  = 29;
   localparam int SID_W  = 11;

   localparam logic [1:0] TYPE_CLASSIC = 2'd2;
   localparam logic [2:0] ACT_OFF      = 3'd0;
   localparam logic [2:0] ACT_REJECT   = 3'd3;
   localparam logic [2:0] ACT_PRIO     = 3'd4;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scan_state_t;

   typedef struct packed {
      logic hit;
      logic accept;
      logic prio;
   } verdict_t;

   function automatic int idx_w(int a, int b);
      return $clog2((a > b) ? a : b);
   endfunction

   function automatic int cnt_w(int a, int b);
      return $clog2(((a > b) ? a : b) + 1);
   endfunction

endpackage

// File: rtl/cif_filter_ram.sv
module cif_filter_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data_a = mem[rd_addr_a];
   assign rd_data_b = mem[rd_addr_b];

endmodule

// File: rtl/cif_elem_match.sv
module cif_elem_match
   import cif_pkg::*;
#(
   parameter bit IS_EXT = 1'b0
) (
   input  logic [WORD_W-1:0] word0,
   input  logic [WORD_W-1:0] word1,
   input  logic [XID_W-1:0]  frame_id,
   output verdict_t          verdict
);
   logic [1:0]       f_type;
   logic [2:0]       f_act;
   logic [XID_W-1:0] f_id;
   logic [XID_W-1:0] f_mask;
   logic [XID_W-1:0] cmp_id;

   generate
      if (IS_EXT) begin : g_ext
         logic unused_ext;
         assign f_act     = word0[31:29];
         assign f_id      = word0[28:0];
         assign f_type    = word1[31:30];
         assign f_mask    = word1[28:0];
         assign cmp_id    = frame_id;
         assign unused_ext = word1[29];
      end else begin : g_std
         logic unused_std;
         assign f_type    = word0[31:30];
         assign f_act     = word0[29:27];
         assign f_id      = {{(XID_W-SID_W){1'b0}}, word0[26:16]};
         assign f_mask    = {{(XID_W-SID_W){1'b0}}, word0[10:0]};
         assign cmp_id    = {{(XID_W-SID_W){1'b0}}, frame_id[SID_W-1:0]};
         assign unused_std = ^{word1, word0[15:11], frame_id[XID_W-1:SID_W]};
      end
   endgenerate

   logic usable;
   assign usable = (f_type == TYPE_CLASSIC) && (f_act != ACT_OFF);

   always_comb begin
      verdict.hit    = usable && (((cmp_id ^ f_id) & f_mask) == '0);
      verdict.accept = (f_act != ACT_REJECT);
      verdict.prio   = (f_act == ACT_PRIO);
   end

endmodule

// File: rtl/cif_scan_ctrl.sv
module cif_scan_ctrl
   import cif_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int MAX_STD = 128,
   parameter int MAX_EXT = 64,
   parameter bit EXT_EN  = 1'b1,
   localparam int SC_W   = $clog2(MAX_STD + 1),
   localparam int EC_W   = $clog2(MAX_EXT + 1),
   localparam int CNT_W  = cnt_w(MAX_STD, MAX_EXT),
   localparam int HIT_W  = idx_w(MAX_STD, MAX_EXT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [XID_W-1:0]  rx_id,
   input  logic              rx_ext,
   input  logic [ADDR_W-1:0] std_base,
   input  logic [SC_W-1:0]   std_count,
   input  logic [ADDR_W-1:0] ext_base,
   input  logic [EC_W-1:0]   ext_count,
   input  verdict_t          std_v,
   input  verdict_t          ext_v,
   output logic [ADDR_W-1:0] rd_addr0,
   output logic [ADDR_W-1:0] rd_addr1,
   output logic [XID_W-1:0]  cur_id,
   output logic              busy,
   output logic              done,
   output logic              accept,
   output logic              prio,
   output logic [HIT_W-1:0]  hit_idx
);
   scan_state_t       state;
   logic [CNT_W-1:0]  idx;
   logic [CNT_W-1:0]  lim;
   logic              ext_q;
   logic [ADDR_W-1:0] base_q;
   logic [XID_W-1:0]  id_q;

   logic [CNT_W-1:0]  std_lim;
   logic [CNT_W-1:0]  ext_lim;
   verdict_t          cur_v;

   assign std_lim = (std_count > SC_W'(MAX_STD)) ? CNT_W'(MAX_STD) : CNT_W'(std_count);

   generate
      if (EXT_EN) begin : g_ext_on
         assign ext_lim = (ext_count > EC_W'(MAX_EXT)) ? CNT_W'(MAX_EXT) : CNT_W'(ext_count);
      end else begin : g_ext_off
         logic unused_cnt;
         assign ext_lim    = '0;
         assign unused_cnt = ^ext_count;
      end
   endgenerate

   always_comb begin
      if (ext_q) begin
         rd_addr0 = base_q + ADDR_W'({idx, 1'b0});
         rd_addr1 = base_q + ADDR_W'({idx, 1'b1});
         cur_v    = ext_v;
      end else begin
         rd_addr0 = base_q + ADDR_W'(idx);
         rd_addr1 = base_q + ADDR_W'(idx) + ADDR_W'(1);
         cur_v    = std_v;
      end
   end

   assign cur_id = id_q;
   assign busy   = (state == ST_SCAN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         lim     <= '0;
         ext_q   <= 1'b0;
         base_q  <= '0;
         id_q    <= '0;
         done    <= 1'b0;
         accept  <= 1'b0;
         prio    <= 1'b0;
         hit_idx <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_SCAN;
                  idx    <= '0;
                  ext_q  <= rx_ext;
                  id_q   <= rx_id;
                  base_q <= rx_ext ? ext_base : std_base;
                  lim    <= rx_ext ? ext_lim : std_lim;
               end
            end
            ST_SCAN: begin
               if (idx == lim) begin
                  state   <= ST_IDLE;
                  done    <= 1'b1;
                  accept  <= 1'b0;
                  prio    <= 1'b0;
                  hit_idx <= '0;
               end else if (cur_v.hit) begin
                  state   <= ST_IDLE;
                  done    <= 1'b1;
                  accept  <= cur_v.accept;
                  prio    <= cur_v.accept && cur_v.prio;
                  hit_idx <= HIT_W'(idx);
               end else begin
                  idx <= idx + CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/can_id_accept_filter.sv
module can_id_accept_filter
   import cif_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int MAX_STD = 128,
   parameter int MAX_EXT = 64,
   parameter bit EXT_EN  = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [ADDR_W-1:0]                     wr_addr,
   input  logic [31:0]                           wr_data,
   input  logic                                  start,
   input  logic [28:0]                           rx_id,
   input  logic                                  rx_ext,
   input  logic [ADDR_W-1:0]                     std_base,
   input  logic [$clog2(MAX_STD+1)-1:0]          std_count,
   input  logic [ADDR_W-1:0]                     ext_base,
   input  logic [$clog2(MAX_EXT+1)-1:0]          ext_count,
   output logic                                  busy,
   output logic                                  done,
   output logic                                  accept,
   output logic                                  prio,
   output logic [idx_w(MAX_STD, MAX_EXT)-1:0]    hit_idx
);
   if (MAX_STD < 2 || MAX_STD > 128) begin : g_bad_std
      $error("MAX_STD must lie in 2..128");
   end
   if (MAX_EXT < 1 || MAX_EXT > 64) begin : g_bad_ext
      $error("MAX_EXT must lie in 1..64");
   end
   if ((1 << ADDR_W) < MAX_STD || (1 << ADDR_W) < 2 * MAX_EXT) begin : g_bad_addr
      $error("ADDR_W too small for the list sizes");
   end

   logic [ADDR_W-1:0] rd_addr0;
   logic [ADDR_W-1:0] rd_addr1;
   logic [WORD_W-1:0] rd_data0;
   logic [WORD_W-1:0] rd_data1;
   logic [XID_W-1:0]  cur_id;
   verdict_t          std_v;
   verdict_t          ext_v;

   cif_filter_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (WORD_W)
   ) u_ram (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (rd_addr0),
      .rd_addr_b (rd_addr1),
      .rd_data_a (rd_data0),
      .rd_data_b (rd_data1)
   );

   cif_elem_match #(.IS_EXT(1'b0)) u_std_match (
      .word0    (rd_data0),
      .word1    (rd_data1),
      .frame_id (cur_id),
      .verdict  (std_v)
   );

   generate
      if (EXT_EN) begin : g_ext_match
         cif_elem_match #(.IS_EXT(1'b1)) u_ext_match (
            .word0    (rd_data0),
            .word1    (rd_data1),
            .frame_id (cur_id),
            .verdict  (ext_v)
         );
      end else begin : g_no_ext
         assign ext_v = '0;
      end
   endgenerate

   cif_scan_ctrl #(
      .ADDR_W  (ADDR_W),
      .MAX_STD (MAX_STD),
      .MAX_EXT (MAX_EXT),
      .EXT_EN  (EXT_EN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rx_id     (rx_id),
      .rx_ext    (rx_ext),
      .std_base  (std_base),
      .std_count (std_count),
      .ext_base  (ext_base),
      .ext_count (ext_count),
      .std_v     (std_v),
      .ext_v     (ext_v),
      .rd_addr0  (rd_addr0),
      .rd_addr1  (rd_addr1),
      .cur_id    (cur_id),
      .busy      (busy),
      .done      (done),
      .accept    (accept),
      .prio      (prio),
      .hit_idx   (hit_idx)
   );

endmodule

// File: rtl/cif_checker.sv
module cif_checker #(
   parameter int MAX_STD = 128,
   parameter int HIT_W   = 7,
   localparam int RUN_W  = $clog2(MAX_STD + 4)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             accept,
   input logic             prio,
   input logic [HIT_W-1:0] hit_idx
);
   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_run <= '0;
      end else if (!busy) begin
         busy_run <= '0;
      end else if (busy_run != '1) begin
         busy_run <= busy_run + RUN_W'(1);
      end
   end

   // R9: result strobe lasts a single cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: the strobe arrives only as a scan ends
   p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9: scan length bounded by the largest list plus one
   p_scan_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RUN_W'(MAX_STD + 1));

   // R2: a start in an idle cycle launches a scan
   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R5: priority flag only on an accepted frame
   p_prio_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prio |-> accept);

   // R12: verdict outputs move only with the strobe
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(accept) && $stable(prio) && $stable(hit_idx)));

endmodule

bind can_id_accept_filter cif_checker #(
   .MAX_STD (MAX_STD),
   .HIT_W   (cif_pkg::idx_w(MAX_STD, MAX_EXT))
) u_cif_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .accept  (accept),
   .prio    (prio),
   .hit_idx (hit_idx)
);

// File: tb/tb_can_id_accept_filter.sv
module tb_can_id_accept_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        start = 1'b0;
   logic [28:0] rx_id = '0;
   logic        rx_ext = 1'b0;
   logic [7:0]  std_base = 8'h10;
   logic [7:0]  std_count = 8'd4;
   logic [7:0]  ext_base = 8'h40;
   logic [6:0]  ext_count = 7'd3;
   logic        busy, done, accept, prio;
   logic [6:0]  hit_idx;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   can_id_accept_filter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .rx_id(rx_id), .rx_ext(rx_ext),
      .std_base(std_base), .std_count(std_count), .ext_base(ext_base), .ext_count(ext_count),
      .busy(busy), .done(done), .accept(accept), .prio(prio), .hit_idx(hit_idx)
   );

   // {ext, id, accept, prio, idx, latency}
   localparam int NV = 11;
   localparam logic [46:0] VEC [NV] = '{
      {1'b0, 29'h123,      1'b1, 1'b0, 7'd0, 8'd1},  // R3 exact, R5 action 1
      {1'b0, 29'h2AB,      1'b1, 1'b1, 7'd1, 8'd2},  // R3 masked, R5 action 4
      {1'b0, 29'h555,      1'b0, 1'b0, 7'd0, 8'd5},  // R6 non-classic skipped, R8
      {1'b0, 29'h305,      1'b0, 1'b0, 7'd3, 8'd4},  // R5 reject action 3
      {1'b0, 29'h7FF,      1'b0, 1'b0, 7'd0, 8'd5},  // R8 no hit
      {1'b0, 29'h1FFFF123, 1'b1, 1'b0, 7'd0, 8'd1},  // R13 upper bits ignored
      {1'b0, 29'h1234567,  1'b0, 1'b0, 7'd0, 8'd5},  // R13 low bits only
      {1'b1, 29'h1234567,  1'b1, 1'b1, 7'd0, 8'd1},  // R4 exact, prio
      {1'b1, 29'h0AB1234,  1'b1, 1'b0, 7'd1, 8'd2},  // R7 first hit wins over reject
      {1'b1, 29'h1234566,  1'b0, 1'b0, 7'd0, 8'd4},  // R4 R8 no hit
      {1'b1, 29'h0000123,  1'b0, 1'b0, 7'd0, 8'd4}   // R4 separate lists
   };

   function automatic logic [31:0] std_el(input logic [1:0] ty, input logic [2:0] act,
                                          input logic [10:0] id, input logic [10:0] mask);
      return {ty, act, id, 5'd0, mask};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      if (!done) begin
         fails++;
         $display("FAIL R9 scan hung actual=%0d expected=done", lat);
      end
   endtask

   task automatic run(input logic [28:0] id, input logic ext, output int lat);
      @(negedge clk);
      start = 1'b1; rx_id = id; rx_ext = ext;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      int lat;
      int extra;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 accept/prio", int'({accept, prio}), 0);
      chk("R1 hit_idx", int'(hit_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", int'({busy, done, accept, prio, hit_idx}), 0);

      // standard list at 0x10
      wr(8'h10, std_el(2'd2, 3'd1, 11'h123, 11'h7FF));
      wr(8'h11, std_el(2'd2, 3'd4, 11'h200, 11'h700));
      wr(8'h12, std_el(2'd1, 3'd1, 11'h555, 11'h7FF));
      wr(8'h13, std_el(2'd2, 3'd3, 11'h300, 11'h7F0));
      wr(8'h14, std_el(2'd2, 3'd1, 11'h555, 11'h7FF));
      wr(8'h15, std_el(2'd2, 3'd0, 11'h666, 11'h7FF));
      // extended list at 0x40
      wr(8'h40, {3'd4, 29'h1234567});
      wr(8'h41, {2'd2, 1'b0, 29'h1FFFFFFF});
      wr(8'h42, {3'd1, 29'h0AB0000});
      wr(8'h43, {2'd2, 1'b0, 29'h1FFF0000});
      wr(8'h44, {3'd3, 29'h0AB1200});
      wr(8'h45, {2'd2, 1'b0, 29'h1FFFFF00});

      for (int v = 0; v < NV; v++) begin
         logic [46:0] e;
         e = VEC[v];
         run(e[45:17], e[46], lat);
         chk($sformatf("R3/R4/R5/R7 vec%0d accept", v), int'(accept), int'(e[16]));
         chk($sformatf("R5 vec%0d prio", v), int'(prio), int'(e[15]));
         chk($sformatf("R7 vec%0d hit_idx", v), int'(hit_idx), int'(e[14:8]));
         chk($sformatf("R9 vec%0d latency", v), lat, int'(e[7:0]));
      end

      // R9 single-cycle strobe
      run(29'h123, 1'b0, lat);
      @(negedge clk);
      chk("R9 done single cycle", int'(done), 0);

      // R12 hold after done
      run(29'h2AB, 1'b0, lat);
      repeat (5) @(negedge clk);
      chk("R12 held verdict", int'({accept, prio, hit_idx}), int'({1'b1, 1'b1, 7'd1}));

      // R8 count zero
      std_count = 8'd0;
      run(29'h123, 1'b0, lat);
      chk("R8 count0 accept", int'(accept), 0);
      chk("R9 count0 latency", lat, 1);

      // R3 element 4 reached with count 5
      std_count = 8'd5;
      run(29'h555, 1'b0, lat);
      chk("R3 idx4 accept", int'({accept, hit_idx}), int'({1'b1, 7'd4}));
      chk("R9 idx4 latency", lat, 5);

      // R5 disabled element with count 6
      std_count = 8'd6;
      run(29'h666, 1'b0, lat);
      chk("R5 action0 skipped", int'(accept), 0);
      chk("R9 count6 latency", lat, 7);
      std_count = 8'd4;

      // R11 inputs changed after start
      @(negedge clk);
      start = 1'b1; rx_id = 29'h7FF; rx_ext = 1'b0;
      @(negedge clk);
      start = 1'b0; rx_id = 29'h123; std_base = 8'h00; std_count = 8'd0; rx_ext = 1'b1;
      wait_done(lat);
      chk("R11 captured accept", int'(accept), 0);
      chk("R11 captured latency", lat, 5);
      std_base = 8'h10; std_count = 8'd4; rx_ext = 1'b0;

      // R2 start during scan ignored
      @(negedge clk);
      start = 1'b1; rx_id = 29'h7FF;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; rx_id = 29'h123;
      @(negedge clk);
      start = 1'b0;
      lat = 2;
      wait_done(lat);
      chk("R2 first result kept", int'(accept), 0);
      extra = 0;
      repeat (8) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R2 no extra done", extra, 0);

      // R10 clamp of standard count
      for (int a = 0; a < 256; a++) wr(8'(a), 32'h0);
      wr(8'h80, std_el(2'd2, 3'd1, 11'h7AA, 11'h7FF));
      std_base = 8'h00; std_count = 8'd200;
      run(29'h7AA, 1'b0, lat);
      chk("R10 clamp accept", int'(accept), 0);
      chk("R10 clamp latency", lat, 129);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule